// File: doc/BRIEF.md
# Banked SRAM Latch Address Manager

This block sits between a host and an external byte-wide SRAM that is reached through three 8-bit address latches. The host works with a flat 20-bit byte address. The block splits that address into 19 physical address bits and a pair of active-low chip selects, one per chip. It then loads the latches over a shared byte bus and performs one read or write strobe. It keeps a shadow copy of what each latch currently holds and reloads only the latches whose value would change. A stream of successive bytes therefore usually costs one latch load per byte.

Up to four host clients can each keep a sequential-access context, which holds a saved 20-bit address. The client selects its context with a 2-bit ID on every request. A sequential read or write uses the context's address and then advances it by one. Because latch reloads are decided against the shadow copy, a client whose stream was interrupted by another client continues at the right address. Only the latches the other client disturbed are rewritten. Single-byte reads and writes carry their own address and leave every context untouched.

The controller is a three-state machine:
- S_IDLE accepts a request. It goes to S_LOAD when at least one latch differs, to S_ACCESS when none differs, and stays in S_IDLE for a context set or an unused code.
- S_LOAD strobes one latch per cycle and moves to S_ACCESS once the last pending latch is written.
- S_ACCESS performs the data strobe and always returns to S_IDLE.

Top module: `sram_latch_mapper`

## Requirements
- R1: After reset, req_ready is 1, lat_stb is 0, sram_rd and sram_wr are 0 and rsp_valid is 0. The shadow copy is invalid, so the first memory request loads all three latches.
- R2: Latch bytes appear on bus_out with bus_oe=1 and exactly one lat_stb bit high. The low latch (lat_stb[0]) receives address bits 7:0 and the mid latch (lat_stb[1]) receives bits 15:8. The high latch (lat_stb[2]) receives bits 18:16 in bits 2:0, address bit 19 in bit 3 (chip 0 select, active low), the inverse of bit 19 in bit 4 (chip 1 select, active low), and zeros in bits 7:5.
- R3: A latch is loaded only if its shadow is invalid or its new byte differs from the shadow. Loads happen one per cycle, in the order low, mid, high.
- R4: The data strobe occurs in the cycle after the last latch load, or in the cycle after acceptance if no load is needed. A read raises sram_rd with bus_oe=0, and bus_in is sampled at the end of that cycle. A write raises sram_wr with bus_oe=1 and bus_out equal to the request's write data.
- R5: req_ready is 1 only in S_IDLE. Every accepted request produces exactly one rsp_valid pulse. For a memory request, the pulse comes in the cycle after the data strobe, and for a read, rsp_rdata carries the sampled byte.
- R6: req_op 2 (set context) stores req_addr into context req_ctx with no bus activity. rsp_valid follows in the next cycle.
- R7: req_op 3 (sequential read) and 4 (sequential write) access the address held by context req_ctx and then advance that context by one. The address wraps from 0xFFFFF to 0x00000.
- R8: Contexts are independent. Interleaving sequential streams of different contexts resumes each stream at its own address, reloading only the latches that differ.
- R9: req_op 0 (single read) and 1 (single write) access req_addr and leave every context unchanged.
- R10: req_op 5, 6 and 7 are accepted and answered with rsp_valid, but change no context, no latch and no memory, and produce no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request (S_IDLE) |
| req_op | input | 3 | 0 single read, 1 single write, 2 set context, 3 sequential read, 4 sequential write, 5-7 unused |
| req_ctx | input | 2 | Context ID for set and sequential operations |
| req_addr | input | 20 | Byte address for single operations and set context |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read from memory |
| bus_out | output | 8 | Shared bus byte (latch value or write data) |
| bus_oe | output | 1 | Block drives the shared bus |
| bus_in | input | 8 | Shared bus as seen during a read |
| lat_stb | output | 3 | One-hot latch load strobes: bit 0 low, bit 1 mid, bit 2 high |
| sram_rd | output | 1 | Read strobe |
| sram_wr | output | 1 | Write strobe |

## Verification
The assertions assume that the host presents only the documented operation codes and holds a request steady until it is accepted. They also assume that the latches really keep what was strobed into them, since the shadow copy is never re-read. The stimulus drives every request at a falling edge while req_ready is high, drops req_valid right after acceptance, and never disturbs the latches outside the block. The bench's memory model therefore decodes exactly what the block strobed.

// File: rtl/sram_lm_pkg.sv
package sram_lm_pkg;

    localparam int BYTE_W  = 8;
    localparam int LAT_N   = 3;
    localparam int LADDR_W = 20;
    localparam int LIDX_W  = $clog2(LAT_N);
    localparam int IMG_W   = BYTE_W * LAT_N;

    typedef enum logic [2:0] {
        OP_RD  = 3'd0,
        OP_WR  = 3'd1,
        OP_SET = 3'd2,
        OP_SRD = 3'd3,
        OP_SWR = 3'd4
    } op_e;

    // Bytes of all three latches for one linear address, low latch in bits 7:0.
    function automatic logic [IMG_W-1:0] latch_image(input logic [LADDR_W-1:0] a);
        logic [BYTE_W-1:0] hi;
        hi = {3'b000, ~a[19], a[19], a[18:16]};
        return {hi, a[15:8], a[7:0]};
    endfunction

    // Index of the lowest pending latch.
    function automatic logic [LIDX_W-1:0] low_idx(input logic [LAT_N-1:0] m);
        logic [LIDX_W-1:0] r;
        r = '0;
        for (int i = LAT_N - 1; i >= 0; i--) begin
            if (m[i]) r = LIDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic is_mem_op(input logic [2:0] op);
        return (op == OP_RD) || (op == OP_WR) || (op == OP_SRD) || (op == OP_SWR);
    endfunction

    function automatic logic is_seq_op(input logic [2:0] op);
        return (op == OP_SRD) || (op == OP_SWR);
    endfunction

    function automatic logic is_wr_op(input logic [2:0] op);
        return (op == OP_WR) || (op == OP_SWR);
    endfunction

endpackage

// File: rtl/sram_lm_ctx.sv
module sram_lm_ctx
    import sram_lm_pkg::*;
#(
    parameter int CTX_N = 4,
    localparam int CTX_W = $clog2(CTX_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTX_W-1:0]   rd_idx,
    output logic [LADDR_W-1:0] rd_addr,
    input  logic               wr_en,
    input  logic [CTX_W-1:0]   wr_idx,
    input  logic [LADDR_W-1:0] wr_addr
);

    logic [LADDR_W-1:0] slot_q [CTX_N];

    for (genvar c = 0; c < CTX_N; c++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[c] <= '0;
            end else if (wr_en && wr_idx == CTX_W'(c)) begin
                slot_q[c] <= wr_addr;
            end
        end
    end

    assign rd_addr = slot_q[rd_idx];

endmodule

// File: rtl/sram_lm_shadow.sv
module sram_lm_shadow
    import sram_lm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IMG_W-1:0]  target,
    output logic [LAT_N-1:0]  diff,
    input  logic              load_en,
    input  logic [LIDX_W-1:0] load_idx,
    input  logic [BYTE_W-1:0] load_byte
);

    logic [BYTE_W-1:0] held_q [LAT_N];
    logic [LAT_N-1:0]  vld_q;

    for (genvar i = 0; i < LAT_N; i++) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q[i] <= '0;
                vld_q[i]  <= 1'b0;
            end else if (load_en && load_idx == LIDX_W'(i)) begin
                held_q[i] <= load_byte;
                vld_q[i]  <= 1'b1;
            end
        end
        assign diff[i] = !vld_q[i] || (held_q[i] != target[i*BYTE_W +: BYTE_W]);
    end

endmodule

// File: rtl/sram_latch_mapper.sv
module sram_latch_mapper
    import sram_lm_pkg::*;
#(
    parameter int CTX_N = 4,
    localparam int CTX_W = $clog2(CTX_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2:0]         req_op,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [LADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [BYTE_W-1:0]  rsp_rdata,
    output logic [BYTE_W-1:0]  bus_out,
    output logic               bus_oe,
    input  logic [BYTE_W-1:0]  bus_in,
    output logic [LAT_N-1:0]   lat_stb,
    output logic               sram_rd,
    output logic               sram_wr
);

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOAD   = 2'd1,
        S_ACCESS = 2'd2
    } state_e;

    state_e st_q, st_d;

    logic [2:0]         op_q;
    logic [CTX_W-1:0]   ctx_q;
    logic [LADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0]  wdata_q;
    logic [IMG_W-1:0]   img_q;
    logic [LAT_N-1:0]   mask_q;
    logic [LAT_N-1:0]   mask_rest;
    logic [LIDX_W-1:0]  cur_idx;
    logic               rsp_q;
    logic [BYTE_W-1:0]  rdata_q;

    logic               accept;
    logic [LADDR_W-1:0] ctx_addr;
    logic [LADDR_W-1:0] tgt_addr;
    logic [IMG_W-1:0]   tgt_img;
    logic [LAT_N-1:0]   diff;
    logic               ctx_we;
    logic [CTX_W-1:0]   ctx_widx;
    logic [LADDR_W-1:0] ctx_wdata;

    assign accept    = (st_q == S_IDLE) && req_valid;
    assign tgt_addr  = is_seq_op(req_op) ? ctx_addr : req_addr;
    assign tgt_img   = latch_image(tgt_addr);
    assign cur_idx   = low_idx(mask_q);
    assign mask_rest = mask_q & (mask_q - 1'b1);

    // Context write: set in S_IDLE, advance after a sequential access.
    assign ctx_we    = (accept && req_op == OP_SET) || (st_q == S_ACCESS && is_seq_op(op_q));
    assign ctx_widx  = (st_q == S_ACCESS) ? ctx_q : req_ctx;
    assign ctx_wdata = (st_q == S_ACCESS) ? addr_q + LADDR_W'(1) : req_addr;

    sram_lm_ctx #(.CTX_N(CTX_N)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_ctx),
        .rd_addr (ctx_addr),
        .wr_en   (ctx_we),
        .wr_idx  (ctx_widx),
        .wr_addr (ctx_wdata)
    );

    sram_lm_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .target    (tgt_img),
        .diff      (diff),
        .load_en   (st_q == S_LOAD),
        .load_idx  (cur_idx),
        .load_byte (img_q[cur_idx*BYTE_W +: BYTE_W])
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (accept && is_mem_op(req_op)) begin
                    st_d = (|diff) ? S_LOAD : S_ACCESS;
                end
            end
            S_LOAD: begin
                if (mask_rest == '0) st_d = S_ACCESS;
            end
            S_ACCESS: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Request capture and response registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            ctx_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            img_q   <= '0;
            mask_q  <= '0;
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rsp_q <= (accept && !is_mem_op(req_op)) || (st_q == S_ACCESS);
            if (accept) begin
                op_q    <= req_op;
                ctx_q   <= req_ctx;
                addr_q  <= tgt_addr;
                wdata_q <= req_wdata;
                img_q   <= tgt_img;
                mask_q  <= diff;
            end else if (st_q == S_LOAD) begin
                mask_q <= mask_rest;
            end
            if (st_q == S_ACCESS && !is_wr_op(op_q)) begin
                rdata_q <= bus_in;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        lat_stb   = '0;
        bus_out   = '0;
        bus_oe    = 1'b0;
        sram_rd   = 1'b0;
        sram_wr   = 1'b0;
        unique case (st_q)
            S_IDLE: req_ready = 1'b1;
            S_LOAD: begin
                lat_stb[cur_idx] = 1'b1;
                bus_out          = img_q[cur_idx*BYTE_W +: BYTE_W];
                bus_oe           = 1'b1;
            end
            S_ACCESS: begin
                if (is_wr_op(op_q)) begin
                    sram_wr = 1'b1;
                    bus_out = wdata_q;
                    bus_oe  = 1'b1;
                end else begin
                    sram_rd = 1'b1;
                end
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_lm_checker.sv
module sram_lm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic [2:0] lat_stb,
    input logic       bus_oe,
    input logic       sram_rd,
    input logic       sram_wr
);

    a_r2_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lat_stb));

    a_r2_stb_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (|lat_stb) |-> bus_oe);

    a_r3_no_low_after_mid: assert property (@(posedge clk) disable iff (!rst_n)
        lat_stb[1] |=> !lat_stb[0]);

    a_r3_high_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        lat_stb[2] |=> (lat_stb == 3'b000));

    a_r4_load_then_access: assert property (@(posedge clk) disable iff (!rst_n)
        (|lat_stb) |=> ((|lat_stb) || sram_rd || sram_wr));

    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_rd && sram_wr));

    a_r4_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        sram_rd |-> !bus_oe);

    a_r4_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        sram_wr |-> bus_oe);

    a_r5_rsp_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_rd || sram_wr) |=> rsp_valid);

    a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lat_stb) || sram_rd || sram_wr) |-> !req_ready);

endmodule

bind sram_latch_mapper sram_lm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .lat_stb   (lat_stb),
    .bus_oe    (bus_oe),
    .sram_rd   (sram_rd),
    .sram_wr   (sram_wr)
);

// File: tb/sram_latch_mapper_tb.sv
module sram_latch_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_ctx = '0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  bus_in = '0;
    logic [2:0]  lat_stb;
    logic        sram_rd;
    logic        sram_wr;

    always #4 clk = ~clk;  // 125 MHz

    sram_latch_mapper u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_op (req_op), .req_ctx (req_ctx), .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .bus_out (bus_out), .bus_oe (bus_oe), .bus_in (bus_in),
        .lat_stb (lat_stb), .sram_rd (sram_rd), .sram_wr (sram_wr)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard queue: kind 0 latch load, 1 data strobe, 2 response.
    int       q_kind[$];
    int       q_idx[$];
    int       q_val[$];
    bit       q_wr[$];
    string    q_tag[$];

    task automatic push(input int kind, input int idx, input int val, input bit wr, input string tag);
        q_kind.push_back(kind);
        q_idx.push_back(idx);
        q_val.push_back(val);
        q_wr.push_back(wr);
        q_tag.push_back(tag);
    endtask

    // Reference model, written from the requirements.
    bit [7:0]  ref_sh[3];
    bit        ref_vld[3];
    bit [19:0] ref_ctx[4];
    bit [7:0]  ref_mem[int];

    function automatic bit [7:0] img_byte(input bit [19:0] a, input int i);
        if (i == 0) return a[7:0];
        if (i == 1) return a[15:8];
        return {3'b000, ~a[19], a[19], a[18:16]};
    endfunction

    task automatic do_req(input bit [2:0] op, input bit [1:0] ctx, input bit [19:0] addr,
                          input bit [7:0] wd, input string tag);
        bit [19:0] tgt;
        bit        wr;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (op == 3'd2) begin
            ref_ctx[ctx] = addr;
            push(2, 0, 0, 1'b1, {tag, " R6 set rsp"});
        end else if (op > 3'd4) begin
            push(2, 0, 0, 1'b1, {tag, " R10 ignored rsp"});
        end else begin
            tgt = (op == 3'd3 || op == 3'd4) ? ref_ctx[ctx] : addr;
            wr  = (op == 3'd1 || op == 3'd4);
            for (int i = 0; i < 3; i++) begin
                if (!ref_vld[i] || ref_sh[i] != img_byte(tgt, i)) begin
                    push(0, i, img_byte(tgt, i), 1'b0, {tag, " R2/R3 latch"});
                    ref_sh[i]  = img_byte(tgt, i);
                    ref_vld[i] = 1'b1;
                end
            end
            push(1, 0, wd, wr, {tag, " R4 strobe"});
            if (wr) ref_mem[int'(tgt)] = wd;
            push(2, 0, ref_mem.exists(int'(tgt)) ? ref_mem[int'(tgt)] : 8'h00, wr,
                 {tag, " R5 rsp"});
            if (op == 3'd3 || op == 3'd4) ref_ctx[ctx] = tgt + 20'd1;
        end
        req_op    = op;
        req_ctx   = ctx;
        req_addr  = addr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // SRAM model (decodes the physical latches) and monitor.
    bit [7:0] m_lat[3];
    bit [7:0] sram_arr[int];

    always @(negedge clk) begin
        int key;
        if (rst_n) begin
            key = {11'd0, m_lat[2][4] ? 1'b0 : 1'b1, m_lat[2][2:0], m_lat[1], m_lat[0]};
            key = (m_lat[2][3] ? (1 << 19) : 0) | (key & 20'h7FFFF);
            if (lat_stb != 3'b000) begin
                chk($onehot(lat_stb), "R2 one-hot strobe", lat_stb, 1);
                for (int i = 0; i < 3; i++) if (lat_stb[i]) m_lat[i] = bus_out;
                if (q_kind.size() == 0 || q_kind[0] != 0) begin
                    chk(0, "R3 unexpected latch load", lat_stb, 0);
                end else begin
                    chk(lat_stb == 3'(1 << q_idx[0]), q_tag[0], lat_stb, 1 << q_idx[0]);
                    chk(bus_out == 8'(q_val[0]) && bus_oe, q_tag[0], bus_out, q_val[0]);
                    void'(q_kind.pop_front()); void'(q_idx.pop_front());
                    void'(q_val.pop_front()); void'(q_wr.pop_front()); void'(q_tag.pop_front());
                end
            end
            if (sram_rd || sram_wr) begin
                if (sram_wr) sram_arr[key] = bus_out;
                else bus_in = sram_arr.exists(key) ? sram_arr[key] : 8'h00;
                if (q_kind.size() == 0 || q_kind[0] != 1) begin
                    chk(0, "R4 unexpected data strobe", {sram_wr, sram_rd}, 0);
                end else begin
                    chk(sram_wr == q_wr[0] && bus_oe == q_wr[0], q_tag[0], sram_wr, q_wr[0]);
                    if (q_wr[0]) chk(bus_out == 8'(q_val[0]), q_tag[0], bus_out, q_val[0]);
                    void'(q_kind.pop_front()); void'(q_idx.pop_front());
                    void'(q_val.pop_front()); void'(q_wr.pop_front()); void'(q_tag.pop_front());
                end
            end
            if (rsp_valid) begin
                if (q_kind.size() == 0 || q_kind[0] != 2) begin
                    chk(0, "R5 unexpected response", 1, 0);
                end else begin
                    if (!q_wr[0]) chk(rsp_rdata == 8'(q_val[0]), q_tag[0], rsp_rdata, q_val[0]);
                    else          chk(1'b1, q_tag[0], 1, 1);
                    void'(q_kind.pop_front()); void'(q_idx.pop_front());
                    void'(q_val.pop_front()); void'(q_wr.pop_front()); void'(q_tag.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(lat_stb == 3'b000 && !sram_rd && !sram_wr, "R1 quiet bus after reset",
            {lat_stb, sram_rd, sram_wr}, 0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);

        do_req(3'd1, 2'd0, 20'h12345, 8'hA5, "R1 cold write");
        do_req(3'd0, 2'd0, 20'h12345, 8'h00, "R3 read no reload");
        do_req(3'd1, 2'd0, 20'h92345, 8'h3C, "R2 chip1 write");
        do_req(3'd0, 2'd0, 20'h12345, 8'h00, "R2 chip0 read back");
        do_req(3'd0, 2'd0, 20'h92345, 8'h00, "R2 chip1 read back");

        do_req(3'd2, 2'd0, 20'h000FE, 8'h00, "R6 ctx0");
        do_req(3'd4, 2'd0, 20'h0,     8'h11, "R7 seq write");
        do_req(3'd4, 2'd0, 20'h0,     8'h22, "R7 seq write");
        do_req(3'd4, 2'd0, 20'h0,     8'h33, "R7 seq write mid carry");
        do_req(3'd2, 2'd1, 20'hFFFFE, 8'h00, "R6 ctx1");
        do_req(3'd4, 2'd1, 20'h0,     8'h44, "R7 seq write top");
        do_req(3'd4, 2'd1, 20'h0,     8'h55, "R7 seq write last");
        do_req(3'd4, 2'd1, 20'h0,     8'h66, "R7 wrap to zero");

        do_req(3'd2, 2'd0, 20'h000FE, 8'h00, "R6 ctx0 rewind");
        do_req(3'd2, 2'd2, 20'hFFFFE, 8'h00, "R6 ctx2");
        do_req(3'd3, 2'd0, 20'h0,     8'h00, "R8 ctx0 read");
        do_req(3'd3, 2'd2, 20'h0,     8'h00, "R8 ctx2 read");
        do_req(3'd3, 2'd0, 20'h0,     8'h00, "R8 ctx0 resume");
        do_req(3'd3, 2'd2, 20'h0,     8'h00, "R8 ctx2 resume");

        do_req(3'd0, 2'd0, 20'h12345, 8'h00, "R9 single read");
        do_req(3'd1, 2'd0, 20'h55555, 8'h77, "R9 single write");
        do_req(3'd3, 2'd0, 20'h0,     8'h00, "R9 ctx0 unaffected");

        do_req(3'd5, 2'd0, 20'hABCDE, 8'hEE, "R10 op5");
        do_req(3'd6, 2'd1, 20'h00000, 8'hEE, "R10 op6");
        do_req(3'd7, 2'd2, 20'h77777, 8'hEE, "R10 op7");
        do_req(3'd3, 2'd0, 20'h0,     8'h00, "R10 ctx0 after ignored");
        do_req(3'd0, 2'd0, 20'h55555, 8'h00, "R10 memory kept");
        do_req(3'd3, 2'd1, 20'h0,     8'h00, "R10 ctx1 kept");

        repeat (10) @(negedge clk);
        chk(q_kind.size() == 0, "R5 all expected events seen", q_kind.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule